// File: doc/BRIEF.md
# Serial Receiver with Ninth-Bit Address Filter

This block recovers asynchronous serial frames from a single data line. A free-running strobe at sixteen times the bit rate (`baud_tick16`) paces a frame state machine that validates the start bit, samples every later bit once at the centre of its sixteen-tick window, checks parity and the first stop bit, and hands each finished word to a four-entry first-word-fall-through queue. Each queue entry carries the word with its own parity and framing flags. A word that arrives while the queue is full is lost and raises a sticky overrun flag, which stays up until `clr_overrun` is pulsed.

The frame layout is set at run time: eight data bits with no, even or odd parity, or nine data bits with no parity, followed by one or two stop bits. The line can be taken from the external pin or, for self-test, from the local transmitter output, and it can be inverted so that an idle-low line works. In address-filter mode with the nine-bit layout, frames whose top data bit is 0 are dropped before the queue, so a node only sees address words until software turns filtering off. Configuration is expected to be changed only while the line is idle.

The frame state machine has six states. IDLE goes to START on a tick that sees the line low. START returns to IDLE (false start) if the line is high at the eighth tick, and goes to DATA if it is low. DATA stays until the last data bit is sampled, then goes to PARITY for the parity formats or to STOP1 otherwise. PARITY goes to STOP1 after one bit time. STOP1 goes to STOP2 when two stop bits are configured, or to IDLE. STOP2 goes to IDLE after one bit time.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset the queue reports empty and not full, and the overrun flag is 0.
- R2: A low level seen on a tick while idle starts a frame only if the line is still low on the eighth tick after it; otherwise the receiver goes back to idle, and a short low pulse of four ticks stores no word.
- R3: Data bits are taken least significant first, each one 16 ticks after the one before, starting 16 ticks after the start-bit check; in the eight-bit layouts `rd_data[8]` reads 0.
- R4: `cfg_fmt` selects the layout: 00 eight bits no parity, 01 eight bits even parity, 10 eight bits odd parity, 11 nine bits no parity.
- R5: In the parity layouts the entry's `rd_perr` is 1 exactly when the data bits and the received parity bit disagree with the selected parity (even: the nine bits have an odd count of ones; odd: an even count); in the other layouts it is 0.
- R6: `rd_ferr` of an entry is 1 when the first stop bit samples low; with `cfg_two_stop` = 1 a low second stop bit does not set it.
- R7: The queue holds four entries, presents its oldest entry on `rd_data`, `rd_perr`, `rd_ferr` whenever `rx_empty` is 0, and removes it on a cycle with `rd_en` = 1; `rx_full` is 1 with four entries held.
- R8: A word that completes while the queue holds four entries is dropped and sets `overrun`, even if `rd_en` is 1 in that cycle; `overrun` stays 1 until a cycle with `clr_overrun` = 1 and no new drop.
- R9: With `cfg_addr_mode` = 1 and the nine-bit layout, a frame whose bit 8 is 0 is not stored and a frame whose bit 8 is 1 is stored; in the eight-bit layouts `cfg_addr_mode` has no effect.
- R10: With `cfg_invert` = 1 the selected input is complemented before use, so the idle level on the wire is low.
- R11: With `cfg_loopback` = 1 the receiver uses `tx_loop` and ignores `rx_pin`; with `cfg_loopback` = 0 it uses `rx_pin` and ignores `tx_loop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_pin | input | 1 | External serial input |
| tx_loop | input | 1 | Local transmitter output for loopback |
| cfg_loopback | input | 1 | 1 selects `tx_loop` as the source |
| cfg_invert | input | 1 | 1 complements the selected source |
| cfg_fmt | input | 2 | Frame layout select (see R4) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_addr_mode | input | 1 | 1 drops nine-bit frames with bit 8 clear |
| rd_en | input | 1 | Remove the oldest queue entry |
| clr_overrun | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 9 | Oldest received word |
| rd_perr | output | 1 | Parity error flag of the oldest word |
| rd_ferr | output | 1 | Framing error flag of the oldest word |
| rx_empty | output | 1 | Queue holds no word |
| rx_full | output | 1 | Queue holds four words |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench aims at a four-tick low glitch, which a receiver that skipped the mid-start check would turn into a phantom word, and at a framing error on the first stop bit driven low for only part of the bit, where a design sampling at the wrong phase would miss it or restart on the tail. A low second stop bit must leave the framing flag clear, which catches a design that checks both stop bits. Five words into a four-entry queue must keep the first four in order and raise an overrun that survives the reads, so a design that overwrote the tail or cleared the flag on read would be caught. Address filtering is tried with bit 8 clear and set and in an eight-bit layout, and loopback runs with the unused source held at a level that would look like a start bit.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        FMT_8N = 2'b00,
        FMT_8E = 2'b01,
        FMT_8O = 2'b10,
        FMT_9B = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [WORD_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic loop_src,
    input  logic use_loop,
    input  logic invert,
    output logic line
);

    logic raw;
    assign raw = (use_loop ? loop_src : pin) ^ invert;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b1;
                else        stage_q <= raw;
            end
            assign line = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw};
            end
            assign line = chain_q[SYNC_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_addr_rx_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line,
    input  fmt_e     fmt,
    input  logic     two_stop,
    output logic     frame_valid,
    output rx_word_t frame_word
);

    localparam int CW = $clog2(TICKS);
    localparam int BW = $clog2(WORD_W);
    localparam logic [CW-1:0] MID_START = CW'(TICKS / 2 - 1);
    localparam logic [CW-1:0] BIT_END   = CW'(TICKS - 1);

    rx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [BW-1:0]     last_bit;
    logic [WORD_W-1:0] shreg;
    logic              par_bit;
    logic              has_parity;
    logic              perr_calc;
    logic              bit_done;

    assign last_bit   = (fmt == FMT_9B) ? BW'(WORD_W - 1) : BW'(WORD_W - 2);
    assign has_parity = (fmt == FMT_8E) || (fmt == FMT_8O);
    assign bit_done   = tick && (cnt == BIT_END);

    always_comb begin
        unique case (fmt)
            FMT_8E:  perr_calc = (^shreg[WORD_W-2:0]) ^ par_bit;
            FMT_8O:  perr_calc = ~((^shreg[WORD_W-2:0]) ^ par_bit);
            default: perr_calc = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  if (tick && cnt == MID_START) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_done && bidx == last_bit) nxt = has_parity ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_done) nxt = ST_STOP1;
            ST_STOP1:  if (bit_done) nxt = two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_done) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            bidx        <= '0;
            shreg       <= '0;
            par_bit     <= 1'b0;
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (tick) begin
                cnt <= (state != nxt || state == ST_IDLE) ? '0 : cnt + 1'b1;
                unique case (state)
                    ST_START: begin
                        bidx  <= '0;
                        shreg <= '0;
                    end
                    ST_DATA: if (cnt == BIT_END) begin
                        shreg[bidx] <= line;
                        bidx        <= bidx + 1'b1;
                    end
                    ST_PARITY: if (cnt == BIT_END) par_bit <= line;
                    ST_STOP1: if (cnt == BIT_END) begin
                        frame_word.data <= shreg;
                        frame_word.perr <= perr_calc;
                        frame_word.ferr <= !line;
                        frame_valid     <= !two_stop;
                    end
                    ST_STOP2: if (cnt == BIT_END) frame_valid <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R2: a start that is high at the mid check falls back to idle
    a_r2_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == MID_START && line) |=> state == ST_IDLE);

    // R3: the bit index never runs past the last data bit while in DATA
    a_r3_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bidx <= last_bit));

    // R6: a word is handed over only after a stop bit, never mid-frame
    a_r6_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (state == ST_IDLE || state == ST_START));

    // R4: the parity state is only reachable in the parity layouts
    a_r4_parity_state_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY && tick) |-> has_parity);

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_addr_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  rx_word_t          din,
    input  logic              pop,
    output rx_word_t          head,
    output logic              empty,
    output logic              full,
    output logic              drop,
    output logic [$clog2(DEPTH):0] level
);

    localparam int AW = $clog2(DEPTH);

    rx_word_t       mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [AW:0]    cnt;
    logic           do_push, do_pop;

    assign full    = (cnt == (AW + 1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW + 1)'(DEPTH));

    // R7: empty and full never together
    a_r7_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R8: a push into a full queue without a pop leaves it full
    a_r8_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_addr_rx_pkg::*;
#(
    parameter int TICKS       = 16,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick16,
    input  logic       rx_pin,
    input  logic       tx_loop,
    input  logic       cfg_loopback,
    input  logic       cfg_invert,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_two_stop,
    input  logic       cfg_addr_mode,
    input  logic       rd_en,
    input  logic       clr_overrun,
    output logic [8:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rx_empty,
    output logic       rx_full,
    output logic       overrun
);

    localparam int LW = $clog2(DEPTH) + 1;

    fmt_e           fmt;
    logic           line;
    logic           frame_valid;
    rx_word_t       frame_word;
    rx_word_t       head;
    logic           keep;
    logic           push;
    logic           drop;
    logic [LW-1:0]  level;

    assign fmt = fmt_e'(cfg_fmt);

    rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (rx_pin),
        .loop_src (tx_loop),
        .use_loop (cfg_loopback),
        .invert   (cfg_invert),
        .line     (line)
    );

    rx_frame_fsm #(.TICKS(TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick16),
        .line        (line),
        .fmt         (fmt),
        .two_stop    (cfg_two_stop),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    assign keep = !(cfg_addr_mode && fmt == FMT_9B && !frame_word.data[WORD_W-1]);
    assign push = frame_valid && keep;

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (frame_word),
        .pop   (rd_en),
        .head  (head),
        .empty (rx_empty),
        .full  (rx_full),
        .drop  (drop),
        .level (level)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (drop)        overrun <= 1'b1;
        else if (clr_overrun) overrun <= 1'b0;
    end

    // R9: a filtered address-mode frame leaves the queue level untouched
    a_r9_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && cfg_addr_mode && fmt == FMT_9B && !frame_word.data[WORD_W-1] && !rd_en)
        |=> $stable(level));

    // R8: overrun stays set until cleared
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_overrun) |=> overrun);

    // R8: a word completing into a full queue raises overrun
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && keep && rx_full) |=> overrun);

endmodule

// File: tb/uart_addr_rx_bench.sv
`timescale 1ns/1ps
module uart_addr_rx_bench;

    localparam int TICK_DIV = 4;
    localparam int NV       = 14;

    typedef struct packed {
        logic [1:0] fmt;
        logic       two;
        logic       inv;
        logic       lpb;
        logic       adr;
        logic [8:0] d;
        logic       badp;
        logic       bads1;
        logic       bads2;
        logic       keep;
        logic       eperr;
        logic       eferr;
    } vec_t;

    //                fmt   two  inv  lpb  adr  data    badp bs1  bs2  keep perr ferr
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0,1'b0,1'b0,1'b0, 9'h0A5, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd1, 1'b0,1'b0,1'b0,1'b0, 9'h037, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd1, 1'b0,1'b0,1'b0,1'b0, 9'h037, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0},
        '{2'd2, 1'b0,1'b0,1'b0,1'b0, 9'h0C1, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0},
        '{2'd2, 1'b0,1'b0,1'b0,1'b0, 9'h05A, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd3, 1'b0,1'b0,1'b0,1'b0, 9'h1A5, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd0, 1'b0,1'b0,1'b0,1'b0, 9'h0E7, 1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1},
        '{2'd0, 1'b1,1'b0,1'b0,1'b0, 9'h01E, 1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0},
        '{2'd3, 1'b1,1'b1,1'b0,1'b0, 9'h0F3, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd3, 1'b0,1'b0,1'b0,1'b1, 9'h0F3, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0},
        '{2'd3, 1'b0,1'b0,1'b0,1'b1, 9'h133, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd1, 1'b0,1'b0,1'b0,1'b1, 9'h081, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd0, 1'b0,1'b0,1'b1,1'b0, 9'h03C, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{2'd2, 1'b1,1'b1,1'b1,1'b0, 9'h096, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_loop = 1'b0;
    logic       cfg_loopback = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_fmt = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_addr_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic       clr_overrun = 1'b0;
    logic [8:0] rd_data;
    logic       rd_perr, rd_ferr, rx_empty, rx_full, overrun;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    uart_addr_rx u_uart_addr_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick16   (baud_tick16),
        .rx_pin        (rx_pin),
        .tx_loop       (tx_loop),
        .cfg_loopback  (cfg_loopback),
        .cfg_invert    (cfg_invert),
        .cfg_fmt       (cfg_fmt),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_addr_mode (cfg_addr_mode),
        .rd_en         (rd_en),
        .clr_overrun   (clr_overrun),
        .rd_data       (rd_data),
        .rd_perr       (rd_perr),
        .rd_ferr       (rd_ferr),
        .rx_empty      (rx_empty),
        .rx_full       (rx_full),
        .overrun       (overrun)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % TICK_DIV;
            baud_tick16 = (div == 0);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // put a logical bit level on the selected source for a number of ticks
    task automatic put(input logic b, input int nticks);
        @(negedge clk);
        if (cfg_loopback) tx_loop = b ^ cfg_invert;
        else              rx_pin  = b ^ cfg_invert;
        repeat (nticks * TICK_DIV - 1) @(negedge clk);
    endtask

    task automatic configure(input vec_t v);
        @(negedge clk);
        cfg_fmt       = v.fmt;
        cfg_two_stop  = v.two;
        cfg_invert    = v.inv;
        cfg_loopback  = v.lpb;
        cfg_addr_mode = v.adr;
        // selected source idles high after inversion; unused source looks like a start
        if (v.lpb) begin tx_loop = ~v.inv; rx_pin  = v.inv; end
        else       begin rx_pin  = ~v.inv; tx_loop = v.inv; end
        repeat (40 * TICK_DIV) @(negedge clk);
    endtask

    task automatic send(input vec_t v);
        int  nb;
        logic p;
        nb = (v.fmt == 2'd3) ? 9 : 8;
        put(1'b0, 16);
        for (int i = 0; i < nb; i++) put(v.d[i], 16);
        if (v.fmt == 2'd1 || v.fmt == 2'd2) begin
            p = (v.fmt == 2'd1) ? ^v.d[7:0] : ~^v.d[7:0];
            put(p ^ v.badp, 16);
        end
        if (v.bads1) begin put(1'b0, 12); put(1'b1, 4); end
        else put(1'b1, 16);
        if (v.two) begin
            if (v.bads2) begin put(1'b0, 12); put(1'b1, 4); end
            else put(1'b1, 16);
        end
        put(1'b1, 32);
    endtask

    task automatic pop_one;
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(rx_empty == 1'b1, "R1 empty after reset", rx_empty, 1);
        chk(rx_full == 1'b0,  "R1 not full after reset", rx_full, 0);
        chk(overrun == 1'b0,  "R1 overrun after reset", overrun, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // table walk: R3 R4 R5 R6 R7 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [8:0] exp_d;
            v = VECS[i];
            exp_d = (v.fmt == 2'd3) ? v.d : {1'b0, v.d[7:0]};
            configure(v);
            send(v);
            @(negedge clk);
            if (v.keep) begin
                chk(rx_empty == 1'b0, "R7/R9/R11 word stored", rx_empty, 0);
                chk(rd_data == exp_d, "R3/R4/R10/R11 data", rd_data, exp_d);
                chk(rd_perr == v.eperr, "R5 parity flag", rd_perr, v.eperr);
                chk(rd_ferr == v.eferr, "R6 framing flag", rd_ferr, v.eferr);
                pop_one();
                @(negedge clk);
            end
            chk(rx_empty == 1'b1, "R9/R11 queue empty after vector", rx_empty, 1);
        end

        // R2: short glitch is rejected, then a good frame is received
        begin
            vec_t g;
            g = VECS[0];
            g.d = 9'h066;
            configure(g);
            put(1'b0, 4);
            put(1'b1, 40);
            @(negedge clk);
            chk(rx_empty == 1'b1, "R2 glitch stores no word", rx_empty, 1);
            send(g);
            @(negedge clk);
            chk(rd_data == 9'h066, "R2 frame after glitch", rd_data, 9'h066);
            pop_one();
            @(negedge clk);
            chk(rx_empty == 1'b1, "R2 only one word", rx_empty, 1);
        end

        // R8: five words into four entries
        begin
            vec_t o;
            o = VECS[0];
            configure(o);
            for (int k = 0; k < 5; k++) begin
                o.d = 9'h010 + 9'(k);
                send(o);
            end
            @(negedge clk);
            chk(rx_full == 1'b1, "R7 full with four words", rx_full, 1);
            chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
            for (int k = 0; k < 4; k++) begin
                chk(rd_data == 9'h010 + 9'(k), "R8 oldest words kept in order", rd_data, 9'h010 + 9'(k));
                pop_one();
                @(negedge clk);
            end
            chk(rx_empty == 1'b1, "R8 fifth word dropped", rx_empty, 1);
            chk(overrun == 1'b1, "R8 overrun sticky across reads", overrun, 1);
            clr_overrun = 1'b1;
            @(negedge clk);
            clr_overrun = 1'b0;
            @(negedge clk);
            chk(overrun == 1'b0, "R8 overrun cleared", overrun, 0);
        end

        finish_run();
    end

endmodule